// File: doc/BRIEF.md
# Multi-Channel PWM Bank with Channel Pairing

This block is a bank of eight pulse-width modulator channels. Each one has its own counter, an 8-bit period and an 8-bit duty value. A control field sets three things for each channel: whether it runs, which output level counts as active, and whether it counts left-aligned or center-aligned. A plain write strobe with an address and a data byte programs every register. All eight output pins are registered.

Two neighbouring channels can be joined into one channel with 16-bit period and duty values. The bank can therefore mix 8-bit and 16-bit channels freely, in steps of one pair. Period and duty writes go into holding registers. A running channel copies them in only when a period ends, so a waveform never shows a truncated or stretched pulse. A single clock-enable input paces every counter in the bank.

Top module: `pwm_bank`

## Requirements
- R1: After synchronous reset all registers are zero and all eight pins read 1 from the first clock edge after reset. This is the inactive level for polarity 0.
- R2: Register map on the 6-bit address. With bit 5 clear, bits 4:2 select the channel and bits 1:0 select the field: 0 is period, 1 is duty, 2 is control, and writes to field 3 are ignored. In the control byte, bit 0 is run, bit 1 is active-high polarity and bit 2 is center mode. With bit 5 set, data bit p of the write is the pairing flag of pair p, which joins channel 2p+1 (high) with channel 2p (low).
- R3: Left-aligned mode. On each tick a running counter steps 0, 1, …, P-1 and then wraps, so the period is P ticks. The pin is active while the count is below D. Each pin is registered, so it reflects the count of the previous clock.
- R4: Center-aligned mode. The counter climbs from 0 to P and then falls back to 1, giving a period of 2P ticks. The pin is active while the count is below D, on the way up and on the way down.
- R5: A duty of 0 keeps the pin inactive. A nonzero duty at or above the period keeps the pin active for the whole period.
- R6: With polarity 1 the active level is high and the idle level is low. With polarity 0 the two levels are swapped.
- R7: Period and duty writes to a running channel take effect at the start of the next period. Writes to a stopped channel take effect at once.
- R8: Clearing run resets the counter to 0 and drives the pin to its inactive level on the next clock. Setting run again starts a fresh period from count 0.
- R9: Counters advance only on clocks where tick is high.
- R10: In a joined pair the period and duty are {high channel byte, low channel byte}. Run, polarity and mode come from the high channel. The low channel's pin stays at the inactive level set by its own polarity bit.
- R11: A pairing flag changes only if both channels of that pair are stopped when it is written. Otherwise the write leaves that flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 8 | Write data |
| pwm_out | output | 8 | Registered PWM pins |

## Verification
The bench targets several corner cases, each with a distinct failure:
- **Duty at or above the period in center mode.** A one-tick dropout at the peak count reveals a plain "count below duty" compare.
- **Period writes in the middle of a period.** An early copy into the active register shows up as a short cycle.
- **Periods of 0 and 1.** Wrong end-of-period detection yields odd period lengths or a stuck counter.
- **Joined pairs.** Wrong byte order gives the wrong 16-bit period. A leak of the low channel's run bit lets its pin toggle.
- **Pairing flag written while a channel runs.** If the write is not refused, the pair splits and the pins diverge from the model.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  typedef enum logic [1:0] {
    FLD_PERIOD = 2'd0,
    FLD_DUTY   = 2'd1,
    FLD_CTRL   = 2'd2,
    FLD_RSVD   = 2'd3
  } fld_e;

  // control byte bits [2:0]: center, act_high, run (run is bit 0)
  typedef struct packed {
    logic center;
    logic act_high;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8,
  localparam int CH_AW = $clog2(NCH),
  localparam int AW    = CH_AW + 3,
  localparam int NPAIR = NCH / 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [CW-1:0]             wr_data,
  output logic [NCH-1:0][CW-1:0]    per_sh,
  output logic [NCH-1:0][CW-1:0]    duty_sh,
  output ctrl_t [NCH-1:0]           ctrl_q,
  output logic [NPAIR-1:0]          cat_q
);

  logic             glob_sel;
  logic [CH_AW-1:0] ch_sel;
  fld_e             fld_sel;

  assign glob_sel = wr_addr[AW-1];
  assign ch_sel   = wr_addr[AW-2:2];
  assign fld_sel  = fld_e'(wr_addr[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_sh  <= '0;
      duty_sh <= '0;
      ctrl_q  <= '0;
      cat_q   <= '0;
    end else if (wr_en) begin
      if (glob_sel) begin
        // a pair may only be joined or split while both halves are stopped
        for (int p = 0; p < NPAIR; p++) begin
          if (!ctrl_q[2*p].run && !ctrl_q[2*p+1].run) begin
            cat_q[p] <= wr_data[p];
          end
        end
      end else begin
        case (fld_sel)
          FLD_PERIOD: per_sh[ch_sel]  <= wr_data;
          FLD_DUTY:   duty_sh[ch_sel] <= wr_data;
          FLD_CTRL:   ctrl_q[ch_sel]  <= ctrl_t'(wr_data[2:0]);
          default:    ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         act_high,
  input  logic         center,
  input  logic [W-1:0] per_sh,
  input  logic [W-1:0] duty_sh,
  output logic         pin
);

  logic [W-1:0] cnt;
  logic [W-1:0] per_a;
  logic [W-1:0] duty_a;
  logic         down;
  logic         active;
  logic         left_end;
  logic         top_hit;
  logic         bottom_hit;

  // full-on when duty reaches the period, so the center peak does not drop out
  assign active     = (duty_a != '0) && ((duty_a >= per_a) || (cnt < duty_a));
  assign left_end   = (per_a == '0) || (cnt >= per_a - 1'b1);
  assign top_hit    = (cnt >= per_a);
  assign bottom_hit = (cnt <= W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      per_a  <= '0;
      duty_a <= '0;
      down   <= 1'b0;
      pin    <= 1'b1;
    end else begin
      pin <= run ? (active ~^ act_high) : ~act_high;
      if (!run) begin
        cnt    <= '0;
        down   <= 1'b0;
        per_a  <= per_sh;
        duty_a <= duty_sh;
      end else if (tick) begin
        if (!center) begin
          down <= 1'b0;
          if (left_end) begin
            cnt    <= '0;
            per_a  <= per_sh;
            duty_a <= duty_sh;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (!down) begin
          if (top_hit) begin
            if (per_a <= W'(1)) begin
              cnt    <= '0;
              per_a  <= per_sh;
              duty_a <= duty_sh;
            end else begin
              cnt  <= cnt - 1'b1;
              down <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          if (bottom_hit) begin
            cnt    <= '0;
            down   <= 1'b0;
            per_a  <= per_sh;
            duty_a <= duty_sh;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_bank_pkg::*;
#(
  parameter int CW = 8,
  localparam int WW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cat,
  input  ctrl_t         c_lo,
  input  ctrl_t         c_hi,
  input  logic [CW-1:0] per_lo,
  input  logic [CW-1:0] duty_lo,
  input  logic [CW-1:0] per_hi,
  input  logic [CW-1:0] duty_hi,
  output logic [1:0]    pins
);

  logic [WW-1:0] per_wide;
  logic [WW-1:0] duty_wide;
  logic          run_lo;

  assign per_wide  = cat ? {per_hi, per_lo}   : {{CW{1'b0}}, per_hi};
  assign duty_wide = cat ? {duty_hi, duty_lo} : {{CW{1'b0}}, duty_hi};
  assign run_lo    = c_lo.run & ~cat;

  pwm_core #(.W(CW)) u_lo (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (run_lo),
    .act_high (c_lo.act_high),
    .center   (c_lo.center),
    .per_sh   (per_lo),
    .duty_sh  (duty_lo),
    .pin      (pins[0])
  );

  pwm_core #(.W(WW)) u_hi (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (c_hi.run),
    .act_high (c_hi.act_high),
    .center   (c_hi.center),
    .per_sh   (per_wide),
    .duty_sh  (duty_wide),
    .pin      (pins[1])
  );

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8,
  localparam int AW = $clog2(NCH) + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_out
);

  localparam int NPAIR = NCH / 2;

  logic [NCH-1:0][CW-1:0] per_sh;
  logic [NCH-1:0][CW-1:0] duty_sh;
  ctrl_t [NCH-1:0]        ctrl_q;
  logic [NPAIR-1:0]       cat_q;

  pwm_regfile #(.NCH(NCH), .CW(CW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .per_sh  (per_sh),
    .duty_sh (duty_sh),
    .ctrl_q  (ctrl_q),
    .cat_q   (cat_q)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_pair #(.CW(CW)) u_pair (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .cat     (cat_q[p]),
      .c_lo    (ctrl_q[2*p]),
      .c_hi    (ctrl_q[2*p+1]),
      .per_lo  (per_sh[2*p]),
      .duty_lo (duty_sh[2*p]),
      .per_hi  (per_sh[2*p+1]),
      .duty_hi (duty_sh[2*p+1]),
      .pins    (pwm_out[2*p+1:2*p])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8,
  localparam int CH_AW = $clog2(NCH),
  localparam int AW    = CH_AW + 3,
  localparam int NPAIR = NCH / 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [2:0]       wr_low,
  input ctrl_t [NCH-1:0]  ctrl_q,
  input logic [NPAIR-1:0] cat_q,
  input logic [NCH-1:0]   pwm_out
);

  AST_RESET_PINS: assert property (@(posedge clk) rst |=> (pwm_out == '1)); // R1

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_addr[AW-1] && (wr_addr[AW-2:2] == CH_AW'(c)) && (wr_addr[1:0] == 2'd2))
      |=> (3'(ctrl_q[c]) == $past(wr_low))); // R2
    AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (rst)
      !ctrl_q[c].run |=> (pwm_out[c] == ~$past(ctrl_q[c].act_high))); // R8
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pr
    AST_PAIR_LOCK: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q[2*p].run || ctrl_q[2*p+1].run) |=> $stable(cat_q[p])); // R11
    AST_LOW_PARKED: assert property (@(posedge clk) disable iff (rst)
      cat_q[p] |=> (pwm_out[2*p] == ~$past(ctrl_q[2*p].act_high))); // R10
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_low  (wr_data[2:0]),
  .ctrl_q  (ctrl_q),
  .cat_q   (cat_q),
  .pwm_out (pwm_out)
);

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] pwm_out;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    model_on = 0;
  string phase = "R1 reset";

  always #2 clk = ~clk;

  pwm_bank dut_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  // behavioural reference state
  int       per_s[8], duty_s[8];
  bit       run_b[8], pol_b[8], cen_b[8];
  bit [3:0] cat_b;
  int       cnt_m[8], pa_m[8], da_m[8];
  bit       dn_m[8];
  bit [7:0] exp_pins = 8'hFF;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit [7:0] nxt;
    if (rst) begin
      for (int c = 0; c < 8; c++) begin
        per_s[c] = 0; duty_s[c] = 0; run_b[c] = 0; pol_b[c] = 0; cen_b[c] = 0;
        cnt_m[c] = 0; pa_m[c] = 0; da_m[c] = 0; dn_m[c] = 0;
      end
      cat_b = '0;
      exp_pins = 8'hFF;
    end else begin
      for (int c = 0; c < 8; c++) begin
        bit joined, live, act;
        int sp, sd;
        joined = cat_b[c/2];
        live   = run_b[c] && !(joined && (c % 2 == 0));
        sp = (joined && c % 2 == 1) ? per_s[c] * 256 + per_s[c-1]   : per_s[c];
        sd = (joined && c % 2 == 1) ? duty_s[c] * 256 + duty_s[c-1] : duty_s[c];
        act = (da_m[c] != 0) && (da_m[c] >= pa_m[c] || cnt_m[c] < da_m[c]);
        nxt[c] = live ? (act == pol_b[c]) : !pol_b[c];
        if (!live) begin
          cnt_m[c] = 0; dn_m[c] = 0; pa_m[c] = sp; da_m[c] = sd;
        end else if (tick) begin
          if (!cen_b[c]) begin
            dn_m[c] = 0;
            if (pa_m[c] == 0 || cnt_m[c] >= pa_m[c] - 1) begin
              cnt_m[c] = 0; pa_m[c] = sp; da_m[c] = sd;
            end else cnt_m[c]++;
          end else if (!dn_m[c]) begin
            if (cnt_m[c] >= pa_m[c]) begin
              if (pa_m[c] <= 1) begin cnt_m[c] = 0; pa_m[c] = sp; da_m[c] = sd; end
              else begin cnt_m[c]--; dn_m[c] = 1; end
            end else cnt_m[c]++;
          end else if (cnt_m[c] <= 1) begin
            cnt_m[c] = 0; dn_m[c] = 0; pa_m[c] = sp; da_m[c] = sd;
          end else cnt_m[c]--;
        end
      end
      if (wr_en) begin
        if (wr_addr[5]) begin
          for (int p = 0; p < 4; p++)
            if (!run_b[2*p] && !run_b[2*p+1]) cat_b[p] = wr_data[p];
        end else begin
          int ch;
          ch = int'(wr_addr[4:2]);
          case (wr_addr[1:0])
            2'd0: per_s[ch] = wr_data;
            2'd1: duty_s[ch] = wr_data;
            2'd2: begin run_b[ch] = wr_data[0]; pol_b[ch] = wr_data[1]; cen_b[ch] = wr_data[2]; end
            default: ;
          endcase
        end
      end
      exp_pins = nxt;
    end
    model_on = 1;
  end

  always @(negedge clk) begin
    if (model_on && !done) chk(pwm_out === exp_pins, phase, pwm_out, exp_pins);
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    chk(pwm_out == 8'hFF, "R1 pins after reset", pwm_out, 8'hFF);

    phase = "R2 reserved field";
    wr(3, 8'hFF);
    idle(3);

    phase = "R3 left-aligned";
    wr(0, 5); wr(1, 2); wr(2, 3);
    wr(4, 4); wr(5, 3); wr(6, 1);
    idle(40);

    phase = "R4 center-aligned";
    wr(8, 4); wr(9, 1); wr(10, 7);
    wr(12, 1); wr(13, 1); wr(14, 5);
    idle(40);

    phase = "R5 duty limits";
    wr(16, 6); wr(17, 0); wr(18, 3);
    wr(20, 6); wr(21, 9); wr(22, 7);
    idle(30);

    phase = "R6 polarity flip";
    wr(6, 3);
    idle(20);

    phase = "R7 shadow update";
    idle(2); wr(0, 3); idle(20); wr(1, 1); idle(12);

    phase = "R8 disable";
    wr(6, 0);
    idle(1);
    chk(pwm_out[1] == 1'b1, "R8 pin inactive after stop", pwm_out[1], 1);
    idle(5); wr(6, 3); idle(20);

    phase = "R9 tick gating";
    repeat (30) begin
      tick = 1'b0; idle(2); tick = 1'b1; idle(1);
    end

    phase = "R10 joined pair";
    wr(24, 8'h2C); wr(25, 8'h64); wr(28, 1); wr(29, 0);
    wr(32, 8); wr(26, 1); wr(30, 3);
    idle(650);
    chk(pwm_out[6] == 1'b1, "R10 low pin parked", pwm_out[6], 1);
    wr(2, 0); wr(6, 0); wr(32, 9);
    wr(0, 10); wr(1, 4); wr(4, 0); wr(5, 0); wr(6, 7);
    idle(60);

    phase = "R11 pairing lock";
    wr(32, 0);
    idle(5);
    chk(pwm_out[6] == 1'b1, "R11 pair stays joined", pwm_out[6], 1);
    wr(26, 0); wr(30, 0); wr(32, 1);
    idle(10);
    wr(30, 3);
    idle(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule